// File: doc/BRIEF.md
# Shared-Pin Thermal and Overvoltage Fault Monitor

This block shares one external shutdown pin between two protection checks and keeps both faults on a single comparator. When it selects the thermal phase, it connects an internal current source to the pin. An external thermistor then sets the pin voltage, and a voltage that is too low means the part is too hot. When it selects the overvoltage phase, it connects an internal pull-down resistor to the pin. The pin then carries a scaled copy of the auxiliary winding, and a voltage that is too high means an output overvoltage. The two checks have opposite polarity, so one comparator flag (pin above threshold) means "safe" in one phase and "fault" in the other.

The monitor counts rising edges of the power-switch gate drive to form a measurement window of `WIN_CYCLES` switching cycles. It reads the comparator only on the falling gate edge that ends the last cycle of the window, so that switching transients have settled. After each clean window it swaps the phase. A startup input raises the comparator threshold during the thermal phase, from the normal 1 V to 1.2 V, through a threshold-select output. A detected fault latches, freezes the phase select and halts the monitor until reset, which models shutdown until power-on reset.

The state machine has three states:

- COUNT: the block counts gate rising edges.
- LAST: the last gate cycle of the window is in progress.
- HALT: a fault has latched.

It has four transitions:

- COUNT→LAST on the `WIN_CYCLES`-th rising edge.
- LAST→COUNT on the gate falling edge when the check passes. The phase swaps on this transition.
- LAST→HALT on the gate falling edge when the check fails.
- HALT holds until reset.

Top module: `sdpin_fault_monitor`

## Requirements
- R1: While `rst_n` is low, `mode_sel` is 1 (thermal phase), `ot_fault` and `ov_fault` are 0, and the window count restarts.
- R2: With `mode_sel`=1, a `cmp_hi` value of 0 at the sampling point sets `ot_fault`.
- R3: `thr_sel` is 1 (1.2 V threshold) exactly when `startup` is 1 and `mode_sel` is 1. Otherwise it is 0 (1 V threshold).
- R4: With `mode_sel`=0, a `cmp_hi` value of 1 at the sampling point sets `ov_fault`.
- R5: The only sampling point is the first clock on which `gate` is seen low after the `WIN_CYCLES`-th rising edge of the window. The value of `cmp_hi` at any other clock has no effect.
- R6: After a window whose sample passes, `mode_sel` inverts. The new phase is visible from the clock edge that took the sample.
- R7: A set fault flag stays set, and `mode_sel` stays frozen, until `rst_n` goes low, whatever the gate or comparator inputs do.
- R8: `ot_fault` and `ov_fault` are never both 1.
- R9: A passing sample leaves both fault flags at 0, and counting continues in the next window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset (power-on reset) |
| gate | input | 1 | Power-switch gate drive, synchronous to clk |
| startup | input | 1 | 1 while the converter is in soft start |
| cmp_hi | input | 1 | Comparator flag: shutdown pin above the selected threshold |
| mode_sel | output | 1 | 1: current source on pin (thermal); 0: pull-down on pin (overvoltage) |
| thr_sel | output | 1 | 1: comparator uses 1.2 V; 0: uses 1 V |
| ot_fault | output | 1 | Latched over-temperature fault |
| ov_fault | output | 1 | Latched overvoltage fault |

## Verification
On every cycle, the assertions check these properties:

- Each fault can only rise in its own phase, and only just after a gate falling edge.
- A phase change happens only at a gate falling edge.
- The fault flags are sticky and never set together.
- The phase select is frozen once a fault is set.
- The high threshold is never selected outside the thermal phase or outside startup.

Only the bench scenarios can show two things. The first is that the sample falls exactly on the last cycle of the window, because comparator noise in earlier cycles is ignored. The second is that the count of rising edges per window is correct.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    typedef enum logic [1:0] {
        SDM_COUNT = 2'd0,
        SDM_LAST  = 2'd1,
        SDM_HALT  = 2'd2
    } sdm_state_e;
endpackage

// File: rtl/sdm_edge.sv
module sdm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/sdm_window.sv
module sdm_window #(
    parameter int WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    output logic done
);
    localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done = en & step & (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en && step) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdpin_fault_monitor.sv
module sdpin_fault_monitor
    import sdm_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic startup,
    input  logic cmp_hi,
    output logic mode_sel,
    output logic thr_sel,
    output logic ot_fault,
    output logic ov_fault
);
    sdm_state_e state_q, state_d;
    logic gate_rise, gate_fall, win_done;
    logic mode_q, ot_q, ov_q;
    logic trip_ot, trip_ov, sample_now;

    sdm_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (gate),
        .rise  (gate_rise),
        .fall  (gate_fall)
    );

    sdm_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == SDM_COUNT),
        .step  (gate_rise),
        .done  (win_done)
    );

    // Polarity differs per phase: thermal fails low, overvoltage fails high.
    assign trip_ot    = mode_q & ~cmp_hi;
    assign trip_ov    = ~mode_q & cmp_hi;
    assign sample_now = (state_q == SDM_LAST) & gate_fall;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SDM_COUNT: if (win_done) state_d = SDM_LAST;
            SDM_LAST:  if (gate_fall) state_d = (trip_ot | trip_ov) ? SDM_HALT : SDM_COUNT;
            SDM_HALT:  state_d = SDM_HALT;
            default:   state_d = SDM_COUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SDM_COUNT;
        else        state_q <= state_d;
    end

    // Output register: phase select and latched faults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b1;
            ot_q   <= 1'b0;
            ov_q   <= 1'b0;
        end else if (sample_now) begin
            ot_q <= trip_ot;
            ov_q <= trip_ov;
            if (!(trip_ot || trip_ov)) mode_q <= ~mode_q;
        end
    end

    assign mode_sel = mode_q;
    assign thr_sel  = mode_q & startup;
    assign ot_fault = ot_q;
    assign ov_fault = ov_q;
endmodule

// File: rtl/sdpin_fault_monitor_chk.sv
module sdpin_fault_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic gate,
    input logic startup,
    input logic mode_sel,
    input logic thr_sel,
    input logic ot_fault,
    input logic ov_fault
);
    AST_OT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ot_fault |=> ot_fault); // R7
    AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ov_fault |=> ov_fault); // R7
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_fault || ov_fault) |=> $stable(mode_sel)); // R7
    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ot_fault && ov_fault)); // R8
    AST_OT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ot_fault) |-> $past(mode_sel)); // R2
    AST_OV_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_fault) |-> !$past(mode_sel)); // R4
    AST_FAULT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ot_fault) || $rose(ov_fault)) |-> (!$past(gate) && $past(gate, 2))); // R5
    AST_SWAP_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_sel) |-> (!$past(gate) && $past(gate, 2))); // R6
    AST_THR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        thr_sel |-> (mode_sel && startup)); // R3
endmodule

bind sdpin_fault_monitor sdpin_fault_monitor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate     (gate),
    .startup  (startup),
    .mode_sel (mode_sel),
    .thr_sel  (thr_sel),
    .ot_fault (ot_fault),
    .ov_fault (ov_fault)
);

// File: tb/sdpin_fault_monitor_bench.sv
`timescale 1ns/100ps
module sdpin_fault_monitor_bench;
    localparam int WIN = 4;

    logic clk = 1'b0;
    logic rst_n, gate, startup, cmp_hi;
    logic mode_sel, thr_sel, ot_fault, ov_fault;
    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    // Behavioural reference state
    bit m_mode, m_ot, m_ov, m_halt, m_armed, m_gprev;
    int m_rises;

    always #2.5 clk = ~clk;

    sdpin_fault_monitor #(.WIN_CYCLES(WIN)) u_sdpin_fault_monitor (
        .clk(clk), .rst_n(rst_n), .gate(gate), .startup(startup), .cmp_hi(cmp_hi),
        .mode_sel(mode_sel), .thr_sel(thr_sel), .ot_fault(ot_fault), .ov_fault(ov_fault)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_mode = 1; m_ot = 0; m_ov = 0; m_halt = 0; m_armed = 0; m_rises = 0;
        end else if (!m_halt) begin
            if (m_armed && !gate && m_gprev) begin
                if (m_mode && !cmp_hi) m_ot = 1;
                else if (!m_mode && cmp_hi) m_ov = 1;
                if (m_ot || m_ov) m_halt = 1;
                else m_mode = !m_mode;
                m_armed = 0;
            end else if (!m_armed && gate && !m_gprev) begin
                m_rises++;
                if (m_rises == WIN) begin m_armed = 1; m_rises = 0; end
            end
        end
        m_gprev = rst_n ? gate : 1'b0;
    end

    // Cycle-by-cycle comparison, away from the active edge
    always begin
        @(negedge clk); #1;
        if (started && !finished) begin
            chk(mode_sel === m_mode, "R6 mode_sel", int'(mode_sel), int'(m_mode));
            chk(ot_fault === m_ot, "R2 ot_fault", int'(ot_fault), int'(m_ot));
            chk(ov_fault === m_ov, "R4 ov_fault", int'(ov_fault), int'(m_ov));
            chk(thr_sel === (m_mode && startup), "R3 thr_sel", int'(thr_sel), int'(m_mode && startup));
        end
    end

    // One window: cmp_hi holds 'noise' except at the sampling clock of the last cycle
    task automatic run_window(input bit noise, input bit endv);
        for (int i = 0; i < WIN; i++) begin
            gate = 1'b1; cmp_hi = noise;
            repeat (2) @(negedge clk);
            gate = 1'b0; cmp_hi = (i == WIN - 1) ? endv : noise;
            @(negedge clk);
            cmp_hi = noise;
            repeat (2) @(negedge clk);
        end
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; gate = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        chk(mode_sel === 1'b1, "R1 reset mode_sel", int'(mode_sel), 1);
        chk(ot_fault === 1'b0 && ov_fault === 1'b0, "R1 reset faults", int'({ot_fault, ov_fault}), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        gate = 0; startup = 1; cmp_hi = 1; rst_n = 0;
        do_reset();
        chk(thr_sel === 1'b1, "R3 startup thermal threshold", int'(thr_sel), 1);

        run_window(1'b1, 1'b1);  // thermal passes
        chk(mode_sel === 1'b0, "R6 swap to overvoltage", int'(mode_sel), 0);
        chk(ot_fault === 1'b0, "R9 pass leaves no fault", int'(ot_fault), 0);
        chk(thr_sel === 1'b0, "R3 low threshold in overvoltage", int'(thr_sel), 0);

        run_window(1'b1, 1'b0);  // overvoltage: noise high earlier, clean at sample
        chk(ov_fault === 1'b0, "R5 noise ignored overvoltage", int'(ov_fault), 0);
        chk(mode_sel === 1'b1, "R6 swap back to thermal", int'(mode_sel), 1);

        run_window(1'b0, 1'b1);  // thermal: noise low earlier, clean at sample
        chk(ot_fault === 1'b0, "R5 noise ignored thermal", int'(ot_fault), 0);
        chk(mode_sel === 1'b0, "R9 counting continues", int'(mode_sel), 0);

        startup = 1'b0;
        run_window(1'b0, 1'b1);  // overvoltage trips
        chk(ov_fault === 1'b1, "R4 overvoltage trip", int'(ov_fault), 1);
        chk(ot_fault === 1'b0, "R8 exclusive faults", int'(ot_fault), 0);
        run_window(1'b0, 1'b0);
        run_window(1'b1, 1'b1);
        chk(ov_fault === 1'b1, "R7 overvoltage sticky", int'(ov_fault), 1);
        chk(mode_sel === 1'b0, "R7 mode frozen", int'(mode_sel), 0);

        do_reset();
        run_window(1'b1, 1'b0);  // thermal trips at normal threshold
        chk(ot_fault === 1'b1, "R2 thermal trip", int'(ot_fault), 1);
        chk(ov_fault === 1'b0, "R8 exclusive faults", int'(ov_fault), 0);
        chk(thr_sel === 1'b0, "R3 no startup threshold", int'(thr_sel), 0);
        run_window(1'b1, 1'b1);
        chk(ot_fault === 1'b1 && mode_sel === 1'b1, "R7 thermal sticky", int'({ot_fault, mode_sel}), 3);

        do_reset();
        run_window(1'b1, 1'b1);
        run_window(1'b0, 1'b0);
        chk(ot_fault === 1'b0 && ov_fault === 1'b0, "R9 two clean windows", int'({ot_fault, ov_fault}), 0);
        chk(mode_sel === 1'b1, "R6 two swaps", int'(mode_sel), 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule